// File: doc/BRIEF.md
# UART Status Flag, Interrupt and DMA Request Unit

This block keeps the seven status flags of a UART and turns them into one interrupt request line and two DMA request lines. The transmit and receive datapaths report events to it as single-cycle pulses: a byte moved from the transmit holding register into the shifter, the last stop bit went out, the receive buffer took its first or second byte, and a parity, framing or overrun error occurred. The bus side reports writes to the flag register, reads of received data and writes of transmit data. A software reset returns every flag to its reset value.

Each flag has its own clear policy. Error and end-of-transmission flags are cleared by writing 1. Parity and framing flags also clear when the errored byte is read. The buffer-level flags clear through receive reads. The transmit-empty flag clears when new transmit data is written. An enable vector masks the flags onto the interrupt line. The receive and transmit DMA requests follow the receive one-byte-full flag and the transmit-empty flag.

Top module: `uart_evt_flags`

## Requirements
- R1: After rst_n is sampled low, flags reads 7'h01: transmit-empty (bit 0) is 1 and every other flag is 0. Bit positions: 0 transmit-empty, 1 transmit-done, 2 receive one-byte-full, 3 receive two-bytes-full, 4 parity error, 5 framing error, 6 overrun.
- R2: A pulse on ev_tx_empty, ev_rx_one, ev_rx_two, ev_par_err, ev_frm_err or ev_ovr_err sets its flag bit at the next clock edge.
- R3: A pulse on ev_tx_done sets bit 1 only if bit 0 is 1 in that cycle. Otherwise it has no effect.
- R4: A cycle with wr_clr high clears each of bits 1, 4, 5 and 6 whose wr_data bit is 1. wr_data bits that are 0, and wr_data bits 0, 2 and 3, have no effect.
- R5: A cycle with rx_rd high clears bit 4 when rx_rd_perr is 1 and clears bit 5 when rx_rd_ferr is 1.
- R6: Every cycle with rx_rd high clears bit 3.
- R7: A cycle with rx_rd and rx_rd_last both high clears bit 2. A read with rx_rd_last low leaves bit 2 unchanged.
- R8: A cycle with tx_wr high clears bit 0.
- R9: When a set event and a clear condition hit the same flag in one cycle, the flag is 1 after the edge.
- R10: soft_rst high returns flags to 7'h01 at the next edge. It overrides all set events of that cycle.
- R11: irq is 1 exactly when (flags & irq_en) is nonzero. It follows changes of irq_en in the same cycle.
- R12: dma_rx_req equals bit 2 and dma_tx_req equals bit 0, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset of all flags |
| ev_tx_done | input | 1 | Stop bit of the last frame sent |
| ev_tx_empty | input | 1 | Transmit byte moved into the shifter |
| ev_rx_one | input | 1 | First byte loaded into empty receive buffer |
| ev_rx_two | input | 1 | Second byte loaded into receive buffer |
| ev_par_err | input | 1 | Parity mismatch on the received byte, reported when it becomes readable |
| ev_frm_err | input | 1 | Framing error on the received byte |
| ev_ovr_err | input | 1 | Received byte lost because the buffer was full |
| wr_clr | input | 1 | Bus write to the flag register |
| wr_data | input | 7 | Write data; 1 bits request a clear |
| rx_rd | input | 1 | Received data read |
| rx_rd_last | input | 1 | This read leaves the receive buffer empty |
| rx_rd_perr | input | 1 | Byte being read carried a parity error |
| rx_rd_ferr | input | 1 | Byte being read carried a framing error |
| tx_wr | input | 1 | Transmit data written |
| irq_en | input | 7 | Per-flag interrupt enable |
| flags | output | 7 | Current flag vector |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
Every flag change caused by an event, a strobe or the software reset shows up one clock edge after the cycle that carried the stimulus. irq and both DMA lines are combinational from the flags and the enables. The bench therefore drives inputs on the falling edge, lets one rising edge pass and compares flags on the next falling edge. It compares irq one nanosecond after changing irq_en, with no clock in between. A long pseudo-random run advances a bench-side model with the same one-edge timing and compares flags, irq and both DMA lines in every cycle.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
// Package: flag positions, reset image and clear masks shared by the
// flag unit and its submodules. Bit positions are visible to software.
package uart_irq_pkg;
    localparam int NUM_FLAGS = 7;
    localparam int FL_TXE = 0;   // transmit buffer empty
    localparam int FL_TXD = 1;   // transmission done
    localparam int FL_RX1 = 2;   // receive one byte full
    localparam int FL_RX2 = 3;   // receive two bytes full
    localparam int FL_PAR = 4;   // parity error
    localparam int FL_FRM = 5;   // framing error
    localparam int FL_OVR = 6;   // overrun error

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    localparam flag_vec_t RST_FLAGS = flag_vec_t'(1) << FL_TXE;
    localparam flag_vec_t W1C_MASK  = (flag_vec_t'(1) << FL_TXD) | (flag_vec_t'(1) << FL_PAR)
                                    | (flag_vec_t'(1) << FL_FRM) | (flag_vec_t'(1) << FL_OVR);
endpackage

// File: rtl/uart_flag_cell.sv
`timescale 1ns/1ps
// Module: one status flag bit.
// Assumes set_i and clr_i are already qualified by the caller; set beats
// clear, soft reset beats both, rst_n is synchronous and active low.
module uart_flag_cell #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Flag storage with reset, set-priority and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) q_o <= RST_VAL;
        else if (set_i)         q_o <= 1'b1;
        else if (clr_i)         q_o <= 1'b0;
    end

    // R9: a set request always leaves the flag at 1
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !soft_rst) |=> q_o);
    // R10: software reset restores the reset value
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (q_o == RST_VAL));
endmodule

// File: rtl/uart_flag_clear.sv
`timescale 1ns/1ps
// Module: builds the per-flag clear vector from the bus-side strobes.
// Assumes each strobe is a single-cycle pulse; purely combinational.
module uart_flag_clear
    import uart_irq_pkg::*;
(
    input  logic      wr_clr,
    input  flag_vec_t wr_data,
    input  logic      rx_rd,
    input  logic      rx_rd_last,
    input  logic      rx_rd_perr,
    input  logic      rx_rd_ferr,
    input  logic      tx_wr,
    output flag_vec_t clr_o
);
    flag_vec_t w1c;

    // Write-one-to-clear applies only to the flags in the mask.
    always_comb w1c = wr_clr ? (wr_data & W1C_MASK) : '0;

    // Merge every clear source into one vector.
    always_comb begin
        clr_o = w1c;
        clr_o[FL_TXE] = tx_wr;
        clr_o[FL_RX2] = rx_rd;
        clr_o[FL_RX1] = rx_rd && rx_rd_last;
        clr_o[FL_PAR] = w1c[FL_PAR] || (rx_rd && rx_rd_perr);
        clr_o[FL_FRM] = w1c[FL_FRM] || (rx_rd && rx_rd_ferr);
    end
endmodule

// File: rtl/uart_irq_combine.sv
`timescale 1ns/1ps
// Module: masks flags onto the interrupt line and taps the DMA requests.
// Assumes flags come straight from registers; purely combinational.
module uart_irq_combine
    import uart_irq_pkg::*;
(
    input  flag_vec_t flags_i,
    input  flag_vec_t en_i,
    output logic      irq_o,
    output logic      dma_rx_o,
    output logic      dma_tx_o
);
    // OR of the enabled flags.
    always_comb irq_o = |(flags_i & en_i);
    // DMA lines follow their source flags.
    always_comb begin
        dma_rx_o = flags_i[FL_RX1];
        dma_tx_o = flags_i[FL_TXE];
    end
endmodule

// File: rtl/uart_evt_flags.sv
`timescale 1ns/1ps
// Module: UART status flag, interrupt and DMA request unit (top).
// Assumes event and strobe inputs are single-cycle pulses synchronous to
// clk. Flags update one edge after their cause; irq and DMA are combinational.
module uart_evt_flags
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 ev_tx_done,
    input  logic                 ev_tx_empty,
    input  logic                 ev_rx_one,
    input  logic                 ev_rx_two,
    input  logic                 ev_par_err,
    input  logic                 ev_frm_err,
    input  logic                 ev_ovr_err,
    input  logic                 wr_clr,
    input  logic [NUM_FLAGS-1:0] wr_data,
    input  logic                 rx_rd,
    input  logic                 rx_rd_last,
    input  logic                 rx_rd_perr,
    input  logic                 rx_rd_ferr,
    input  logic                 tx_wr,
    input  logic [NUM_FLAGS-1:0] irq_en,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq,
    output logic                 dma_rx_req,
    output logic                 dma_tx_req
);
    flag_vec_t set_v;
    flag_vec_t clr_v;

    // Collect set events; transmit-done is gated by the current empty flag.
    always_comb begin
        set_v         = '0;
        set_v[FL_TXE] = ev_tx_empty;
        set_v[FL_TXD] = ev_tx_done && flags[FL_TXE];
        set_v[FL_RX1] = ev_rx_one;
        set_v[FL_RX2] = ev_rx_two;
        set_v[FL_PAR] = ev_par_err;
        set_v[FL_FRM] = ev_frm_err;
        set_v[FL_OVR] = ev_ovr_err;
    end

    uart_flag_clear u_clear (
        .wr_clr     (wr_clr),
        .wr_data    (wr_data),
        .rx_rd      (rx_rd),
        .rx_rd_last (rx_rd_last),
        .rx_rd_perr (rx_rd_perr),
        .rx_rd_ferr (rx_rd_ferr),
        .tx_wr      (tx_wr),
        .clr_o      (clr_v)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        uart_flag_cell #(.RST_VAL(RST_FLAGS[i])) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .set_i    (set_v[i]),
            .clr_i    (clr_v[i]),
            .q_o      (flags[i])
        );
    end

    uart_irq_combine u_comb (
        .flags_i  (flags),
        .en_i     (irq_en),
        .irq_o    (irq),
        .dma_rx_o (dma_rx_req),
        .dma_tx_o (dma_tx_req)
    );

    // R3: transmit-done cannot rise while the transmit buffer is not empty
    a_r3_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && ev_tx_done && !flags[FL_TXE] && !flags[FL_TXD]) |=> !flags[FL_TXD]);
    // R4: a write of all zeros with no other activity changes nothing
    a_r4_zero_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && wr_data == '0 && !soft_rst && !rx_rd && !tx_wr && !ev_tx_done
         && !ev_tx_empty && !ev_rx_one && !ev_rx_two && !ev_par_err && !ev_frm_err
         && !ev_ovr_err) |=> $stable(flags));
    // R7: a read that empties the buffer drops the one-byte-full flag
    a_r7_last_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && rx_rd_last && !ev_rx_one && !soft_rst) |=> !flags[FL_RX1]);
    // R8: a transmit write drops the empty flag unless it is set again
    a_r8_tx_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !ev_tx_empty && !soft_rst) |=> !flags[FL_TXE]);
    // R11: with nothing enabled the interrupt line stays low
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);
    // R12: a receive DMA request only rises after a one-byte-full event
    a_r12_rx_dma_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rx_req) |-> $past(ev_rx_one));
endmodule

// File: tb/uart_evt_flags_tb.sv
`timescale 1ns/1ps
module uart_evt_flags_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst, ev_tx_done, ev_tx_empty, ev_rx_one, ev_rx_two;
    logic ev_par_err, ev_frm_err, ev_ovr_err, wr_clr, rx_rd, rx_rd_last;
    logic rx_rd_perr, rx_rd_ferr, tx_wr;
    logic [6:0] wr_data, irq_en, flags;
    logic irq, dma_rx_req, dma_tx_req;
    logic [6:0] exp_f;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_evt_flags u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev_tx_done(ev_tx_done),
        .ev_tx_empty(ev_tx_empty), .ev_rx_one(ev_rx_one), .ev_rx_two(ev_rx_two),
        .ev_par_err(ev_par_err), .ev_frm_err(ev_frm_err), .ev_ovr_err(ev_ovr_err),
        .wr_clr(wr_clr), .wr_data(wr_data), .rx_rd(rx_rd), .rx_rd_last(rx_rd_last),
        .rx_rd_perr(rx_rd_perr), .rx_rd_ferr(rx_rd_ferr), .tx_wr(tx_wr),
        .irq_en(irq_en), .flags(flags), .irq(irq), .dma_rx_req(dma_rx_req),
        .dma_tx_req(dma_tx_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        soft_rst = 0; ev_tx_done = 0; ev_tx_empty = 0; ev_rx_one = 0; ev_rx_two = 0;
        ev_par_err = 0; ev_frm_err = 0; ev_ovr_err = 0; wr_clr = 0; wr_data = 0;
        rx_rd = 0; rx_rd_last = 0; rx_rd_perr = 0; rx_rd_ferr = 0; tx_wr = 0;
    endtask

    // Next flag vector, written from the requirements.
    function automatic logic [6:0] model(input logic [6:0] f);
        logic [6:0] s, c;
        if (soft_rst) return 7'h01;
        s = {ev_ovr_err, ev_frm_err, ev_par_err, ev_rx_two, ev_rx_one,
             ev_tx_done & f[0], ev_tx_empty};
        c = wr_clr ? (wr_data & 7'h72) : 7'h00;
        c[0] = tx_wr;
        c[3] = rx_rd;
        c[2] = rx_rd & rx_rd_last;
        c[4] = c[4] | (rx_rd & rx_rd_perr);
        c[5] = c[5] | (rx_rd & rx_rd_ferr);
        return s | (f & ~c);
    endfunction

    // Apply current inputs for one rising edge, then return to idle.
    task automatic tick();
        exp_f = model(exp_f);
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic pulse_event(input int i);
        case (i)
            0: ev_tx_empty = 1;
            1: ev_tx_done  = 1;
            2: ev_rx_one   = 1;
            3: ev_rx_two   = 1;
            4: ev_par_err  = 1;
            5: ev_frm_err  = 1;
            default: ev_ovr_err = 1;
        endcase
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        irq_en = 0;
        exp_f = 7'h01;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset flags", flags, 7'h01);
        chk("R12 reset dma_tx", dma_tx_req, 1);
        chk("R12 reset dma_rx", dma_rx_req, 0);
        chk("R11 reset irq masked", irq, 0);

        // R2: each event alone sets its own bit
        for (int i = 0; i < 7; i++) begin
            pulse_event(i); tick();
            chk("R2 single event set", flags, 7'h01 | (7'h01 << i));
            soft_rst = 1; tick();
            chk("R10 soft reset", flags, 7'h01);
        end

        // R8 and R3
        tx_wr = 1; tick();
        chk("R8 tx write clears empty", flags, 7'h00);
        chk("R12 dma_tx drops", dma_tx_req, 0);
        ev_tx_done = 1; tick();
        chk("R3 done ignored when not empty", flags, 7'h00);
        ev_tx_empty = 1; tick();
        chk("R2 empty set", flags, 7'h01);
        ev_tx_done = 1; tick();
        chk("R3 done set when empty", flags, 7'h03);

        // R4 write-one-to-clear
        ev_rx_one = 1; ev_rx_two = 1; ev_par_err = 1; ev_frm_err = 1; ev_ovr_err = 1; tick();
        chk("R2 all set", flags, 7'h7F);
        wr_clr = 1; wr_data = 7'h00; tick();
        chk("R4 zero write inert", flags, 7'h7F);
        wr_clr = 1; wr_data = 7'h0D; tick();
        chk("R4 non-w1c bits inert", flags, 7'h7F);
        wr_clr = 1; wr_data = 7'h42; tick();
        chk("R4 clear done and overrun", flags, 7'h3D);

        // R5, R6, R7 receive reads
        rx_rd = 1; rx_rd_perr = 1; tick();
        chk("R5 R6 errored read clears parity and two-full", flags, 7'h25);
        rx_rd = 1; rx_rd_ferr = 1; rx_rd_last = 1; tick();
        chk("R5 R7 last read clears framing and one-full", flags, 7'h01);
        ev_rx_one = 1; ev_rx_two = 1; tick();
        rx_rd = 1; tick();
        chk("R7 non-last read keeps one-full R6 clears two-full", flags, 7'h05);
        rx_rd = 1; rx_rd_last = 1; tick();
        chk("R7 last read clears one-full", flags, 7'h01);

        // R9 set wins
        ev_par_err = 1; wr_clr = 1; wr_data = 7'h10; tick();
        chk("R9 set beats write clear", flags, 7'h11);
        ev_par_err = 1; rx_rd = 1; rx_rd_perr = 1; tick();
        chk("R9 set beats read clear", flags, 7'h11);
        ev_tx_empty = 1; tx_wr = 1; tick();
        chk("R9 set beats tx write", flags, 7'h11);

        // R10 soft reset beats events
        ev_rx_one = 1; ev_ovr_err = 1; ev_frm_err = 1; soft_rst = 1; tick();
        chk("R10 soft reset overrides sets", flags, 7'h01);

        // R11 enable sweep over two flag states, R12 DMA taps
        for (int st = 0; st < 2; st++) begin
            if (st == 1) begin
                tx_wr = 1; ev_rx_one = 1; ev_par_err = 1; ev_ovr_err = 1; tick();
                chk("R12 dma_rx follows one-full", dma_rx_req, 1);
                chk("R12 dma_tx follows empty", dma_tx_req, 0);
            end
            for (int e = 0; e < 128; e++) begin
                irq_en = 7'(e);
                #1;
                chk("R11 irq mask", irq, (((st == 1) ? 7'h54 : 7'h01) & 7'(e)) != 0);
            end
            @(negedge clk);
        end

        // Pseudo-random sweep against the model, all requirements at once.
        soft_rst = 1; tick();
        for (int n = 0; n < 4000; n++) begin
            soft_rst    = ($urandom % 64) == 0;
            ev_tx_done  = ($urandom % 4) == 0;
            ev_tx_empty = ($urandom % 5) == 0;
            ev_rx_one   = ($urandom % 6) == 0;
            ev_rx_two   = ($urandom % 6) == 0;
            ev_par_err  = ($urandom % 7) == 0;
            ev_frm_err  = ($urandom % 7) == 0;
            ev_ovr_err  = ($urandom % 7) == 0;
            wr_clr      = ($urandom % 4) == 0;
            wr_data     = 7'($urandom);
            rx_rd       = ($urandom % 3) == 0;
            rx_rd_last  = $urandom % 2;
            rx_rd_perr  = $urandom % 2;
            rx_rd_ferr  = $urandom % 2;
            tx_wr       = ($urandom % 4) == 0;
            irq_en      = 7'($urandom);
            tick();
            chk("R2-sweep flags vs model (R3 R4 R5 R6 R7 R8 R9 R10)", flags, exp_f);
            chk("R11 sweep irq", irq, (exp_f & irq_en) != 0);
            chk("R12 sweep dma", {dma_rx_req, dma_tx_req}, {exp_f[2], exp_f[0]});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule